// File: doc/BRIEF.md
# Noise-Shaped Multibit Word Segmenter

This block sits between a multibit sigma-delta modulator and the unit-element arrays of a current-steering converter. At the oversampled rate it takes each signed 8-bit modulator word and splits it into three smaller codes with binary weights of 16, 4 and 1. The coarse code is 4 bits wide and the two finer codes are 3 bits wide. Each code can then drive its own small element array instead of one large one.

The split is made in two cascaded error-feedback stages. The coarse stage rounds the sample, plus its stored residue, to a multiple of 16. The error of that rounding is saturated, stored, and added into the next sample. Because of this feedback, the error left by the coarse decision is first-order high-passed. The middle stage does the same at weight 4 on what remains. The fine code takes the exact final remainder. Each rounded code is clamped so that the stages below it can always represent what is left. As a result, the weighted sum of the three codes equals the input sample exactly, and only the split between segments carries shaped error.

All three codes leave the block in sign-and-magnitude form, for direct use by switched current sources. The codes are registered together and appear one clock after the accepted sample.

Top module: `nss_segmenter`

## Requirements
- R1: Synchronous active-high reset clears both residues and all outputs, and drives `out_valid` low. Reset takes priority over `in_valid` in the same cycle. After reset, a stream of zero samples gives zero on all three codes.
- R2: For every accepted sample x, 16·hi + 4·mid + lo = x exactly, where hi, mid and lo are the signed values of the three codes.
- R3: The signed code values stay inside their ranges: hi in [−8, 7], mid in [−4, 3], lo in [−4, 3]. The coarse residue e1 stays in [−8, 7] and the middle residue e2 stays in [−2, 1].
- R4: A sample presented with `in_valid` high is answered on the next clock with `out_valid` high. Without `in_valid`, `out_valid` goes low on the next clock and the codes hold their values.
- R5: Coarse rule. With v = x + e1, hi = floor((v + 8)/16) is first clamped to [ceil((x − 15)/16), floor((x + 20)/16)] and then to [−8, 7]. The new e1 is v − 16·hi, saturated to [−8, 7].
- R6: Middle rule. With r = x − 16·hi and v = r + e2, mid = floor((v + 2)/4) is first clamped to [ceil((r − 3)/4), floor((r + 4)/4)] and then to [−4, 3]. The new e2 is v − 4·mid, saturated to [−2, 1]. Finally, lo = r − 4·mid.
- R7: Each code is output as a sign bit, which is 1 only for a negative value, and a magnitude equal to the absolute value. Zero is always sent with the sign bit at 0.
- R8: Cycles without `in_valid` leave both residues unchanged, so the codes that follow a gap are the same as if the gap were absent.
- R9: For a constant input, the sum of 16·hi over N accepted samples differs from N·x by no more than 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 8 | Signed two's-complement modulator word |
| out_valid | output | 1 | Codes updated this cycle |
| hi_neg | output | 1 | Sign of the weight-16 code |
| hi_mag | output | 4 | Magnitude of the weight-16 code (0..8) |
| mid_neg | output | 1 | Sign of the weight-4 code |
| mid_mag | output | 3 | Magnitude of the weight-4 code (0..4) |
| lo_neg | output | 1 | Sign of the weight-1 code |
| lo_mag | output | 3 | Magnitude of the weight-1 code (0..4) |

## Verification
Two functions can fall in the same cycle: a synchronous reset and an accepted sample. The bench drives a nonzero sample with `in_valid` high while reset is asserted, in the middle of a stream whose residues are nonzero. It then expects zero codes and a low `out_valid`, and it expects that the zero samples that follow also give zero codes, which shows that no residue was written. In the same spirit, extreme input samples are fed so that the range clamp and the residue saturation act in the same cycle. These cases are judged by the exact weighted sum and by bit-exact agreement with a model of the stage rules.

// File: rtl/nss_pkg.sv
package nss_pkg;

    localparam int IN_W   = 8;
    localparam int HI_W   = 4;
    localparam int MID_W  = 3;
    localparam int LO_W   = 3;
    localparam int HI_SH  = 4;
    localparam int MID_SH = 2;
    localparam int DW     = IN_W + 4;

    function automatic int code_min(input int w);
        return -(1 << (w - 1));
    endfunction

    function automatic int code_max(input int w);
        return (1 << (w - 1)) - 1;
    endfunction

    // Span that the stages below a split can still absorb
    localparam int LO_CAP_MIN  = code_min(LO_W);
    localparam int LO_CAP_MAX  = code_max(LO_W);
    localparam int MID_CAP_MIN = code_min(MID_W) * (1 << MID_SH) + LO_CAP_MIN;
    localparam int MID_CAP_MAX = code_max(MID_W) * (1 << MID_SH) + LO_CAP_MAX;

    typedef struct packed {
        logic            neg;
        logic [HI_W-1:0] mag;
    } hi_sm_t;

    typedef struct packed {
        logic             neg;
        logic [MID_W-1:0] mag;
    } mid_sm_t;

    typedef struct packed {
        logic            neg;
        logic [LO_W-1:0] mag;
    } lo_sm_t;

endpackage

// File: rtl/nss_split_stage.sv
module nss_split_stage #(
    parameter int DW      = 12,
    parameter int CODE_W  = 4,
    parameter int SH      = 4,
    parameter int CAP_MIN = -20,
    parameter int CAP_MAX = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [DW-1:0]     x,
    output logic signed [CODE_W-1:0] q,
    output logic signed [DW-1:0]     rem
);

    localparam logic signed [DW-1:0] K_HALF = DW'((1 << SH) / 2);
    localparam logic signed [DW-1:0] K_WM1  = DW'((1 << SH) - 1);
    localparam logic signed [DW-1:0] K_EMAX = DW'((1 << SH) / 2 - 1);
    localparam logic signed [DW-1:0] K_EMIN = DW'(-((1 << SH) / 2));
    localparam logic signed [DW-1:0] K_QMAX = DW'((1 << (CODE_W - 1)) - 1);
    localparam logic signed [DW-1:0] K_QMIN = DW'(-(1 << (CODE_W - 1)));
    localparam logic signed [DW-1:0] K_CMAX = DW'(CAP_MAX);
    localparam logic signed [DW-1:0] K_CMIN = DW'(CAP_MIN);

    logic signed [DW-1:0] resid_q;
    logic signed [DW-1:0] v, q_round, b_lo, b_hi, q_lo, q_hi, q_c, err, err_sat;

    always_comb begin
        v       = x + resid_q;
        q_round = (v + K_HALF) >>> SH;
        // keep the remainder inside what lower stages can express
        b_lo    = (x - K_CMAX + K_WM1) >>> SH;
        b_hi    = (x - K_CMIN) >>> SH;
        q_lo    = (b_lo > K_QMIN) ? b_lo : K_QMIN;
        q_hi    = (b_hi < K_QMAX) ? b_hi : K_QMAX;
        if (q_round < q_lo)
            q_c = q_lo;
        else if (q_round > q_hi)
            q_c = q_hi;
        else
            q_c = q_round;
        err = v - (q_c <<< SH);
        if (err > K_EMAX)
            err_sat = K_EMAX;
        else if (err < K_EMIN)
            err_sat = K_EMIN;
        else
            err_sat = err;
        rem = x - (q_c <<< SH);
        q   = CODE_W'(q_c);
    end

    always_ff @(posedge clk) begin
        if (rst)
            resid_q <= '0;
        else if (en)
            resid_q <= err_sat;
    end

endmodule

// File: rtl/nss_sm_encode.sv
module nss_sm_encode #(
    parameter int CODE_W = 4
) (
    input  logic signed [CODE_W-1:0] code,
    output logic                     neg,
    output logic [CODE_W-1:0]        mag
);

    always_comb begin
        neg = code[CODE_W-1];
        mag = neg ? CODE_W'(-code) : CODE_W'(code);
    end

endmodule

// File: rtl/nss_segmenter.sv
module nss_segmenter
    import nss_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    output logic                   out_valid,
    output logic                   hi_neg,
    output logic [HI_W-1:0]        hi_mag,
    output logic                   mid_neg,
    output logic [MID_W-1:0]       mid_mag,
    output logic                   lo_neg,
    output logic [LO_W-1:0]        lo_mag
);

    logic signed [DW-1:0]    x_ext, rem1, rem2;
    logic signed [HI_W-1:0]  hi_code;
    logic signed [MID_W-1:0] mid_code;
    logic signed [LO_W-1:0]  lo_code;
    hi_sm_t  hi_d, hi_q;
    mid_sm_t mid_d, mid_q;
    lo_sm_t  lo_d, lo_q;
    logic    valid_q;

    assign x_ext = DW'(in_sample);

    nss_split_stage #(
        .DW(DW), .CODE_W(HI_W), .SH(HI_SH),
        .CAP_MIN(MID_CAP_MIN), .CAP_MAX(MID_CAP_MAX)
    ) u_coarse (
        .clk(clk), .rst(rst), .en(in_valid),
        .x(x_ext), .q(hi_code), .rem(rem1)
    );

    nss_split_stage #(
        .DW(DW), .CODE_W(MID_W), .SH(MID_SH),
        .CAP_MIN(LO_CAP_MIN), .CAP_MAX(LO_CAP_MAX)
    ) u_middle (
        .clk(clk), .rst(rst), .en(in_valid),
        .x(rem1), .q(mid_code), .rem(rem2)
    );

    assign lo_code = LO_W'(rem2);

    nss_sm_encode #(.CODE_W(HI_W)) u_enc_hi (
        .code(hi_code), .neg(hi_d.neg), .mag(hi_d.mag)
    );
    nss_sm_encode #(.CODE_W(MID_W)) u_enc_mid (
        .code(mid_code), .neg(mid_d.neg), .mag(mid_d.mag)
    );
    nss_sm_encode #(.CODE_W(LO_W)) u_enc_lo (
        .code(lo_code), .neg(lo_d.neg), .mag(lo_d.mag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            hi_q    <= '0;
            mid_q   <= '0;
            lo_q    <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                hi_q  <= hi_d;
                mid_q <= mid_d;
                lo_q  <= lo_d;
            end
        end
    end

    assign out_valid = valid_q;
    assign hi_neg    = hi_q.neg;
    assign hi_mag    = hi_q.mag;
    assign mid_neg   = mid_q.neg;
    assign mid_mag   = mid_q.mag;
    assign lo_neg    = lo_q.neg;
    assign lo_mag    = lo_q.mag;

endmodule

// File: rtl/nss_segmenter_chk.sv
module nss_segmenter_chk
    import nss_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic signed [IN_W-1:0] in_sample,
    input logic                   out_valid,
    input logic                   hi_neg,
    input logic [HI_W-1:0]        hi_mag,
    input logic                   mid_neg,
    input logic [MID_W-1:0]       mid_mag,
    input logic                   lo_neg,
    input logic [LO_W-1:0]        lo_mag
);

    int hv, mv, lv, total;

    always_comb begin
        hv    = hi_neg  ? -int'(hi_mag)  : int'(hi_mag);
        mv    = mid_neg ? -int'(mid_mag) : int'(mid_mag);
        lv    = lo_neg  ? -int'(lo_mag)  : int'(lo_mag);
        total = hv * (1 << HI_SH) + mv * (1 << MID_SH) + lv;
    end

    // R1: reset clears the outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && hi_mag == '0 && mid_mag == '0 && lo_mag == '0
                 && !hi_neg && !mid_neg && !lo_neg));

    // R2: weighted sum reproduces the accepted sample
    assert_exact_sum_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (total == int'($past(in_sample))));

    // R3: signed code ranges
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (hv >= code_min(HI_W) && hv <= code_max(HI_W) &&
         mv >= code_min(MID_W) && mv <= code_max(MID_W) &&
         lv >= code_min(LO_W) && lv <= code_max(LO_W)));

    // R4: one-cycle strobe latency
    assert_valid_follow_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drop_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R4: codes hold when no sample is taken
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(hi_mag) && $stable(mid_mag) && $stable(lo_mag)
                       && $stable(hi_neg) && $stable(mid_neg) && $stable(lo_neg)));

    // R7: zero never carries a negative sign
    assert_sign_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !((hi_neg && hi_mag == '0) || (mid_neg && mid_mag == '0) ||
          (lo_neg && lo_mag == '0)));

endmodule

bind nss_segmenter nss_segmenter_chk u_chk (.*);

// File: tb/nss_segmenter_tb.sv
module nss_segmenter_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [7:0] in_sample = '0;
    logic              out_valid;
    logic              hi_neg, mid_neg, lo_neg;
    logic [3:0]        hi_mag;
    logic [2:0]        mid_mag, lo_mag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int e1 = 0, e2 = 0;
    int exp_h = 0, exp_m = 0, exp_l = 0;

    always #4 clk = ~clk;

    nss_segmenter u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid),
        .hi_neg(hi_neg), .hi_mag(hi_mag),
        .mid_neg(mid_neg), .mid_mag(mid_mag),
        .lo_neg(lo_neg), .lo_mag(lo_mag)
    );

    function automatic int clampi(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic int sm_val(input logic neg, input int mag);
        return neg ? -mag : mag;
    endfunction

    // Stage rules of R5 and R6, with residues advanced (R8: only on accepted samples)
    task automatic model(input int x);
        int v, q, lb, hb, r;
        v  = x + e1;
        q  = (v + 8) >>> 4;
        lb = clampi((x - 15 + 15) >>> 4, -8, 7);
        hb = clampi((x + 20) >>> 4, -8, 7);
        q  = clampi(q, lb, hb);
        e1 = clampi(v - 16 * q, -8, 7);
        exp_h = q;
        r  = x - 16 * q;
        v  = r + e2;
        q  = (v + 2) >>> 2;
        lb = clampi((r - 3 + 3) >>> 2, -4, 3);
        hb = clampi((r + 4) >>> 2, -4, 3);
        q  = clampi(q, lb, hb);
        e2 = clampi(v - 4 * q, -2, 1);
        exp_m = q;
        exp_l = r - 4 * q;
    endtask

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic check_outputs(input string tag, input logic exp_valid);
        int h, m, l;
        h = sm_val(hi_neg, int'(hi_mag));
        m = sm_val(mid_neg, int'(mid_mag));
        l = sm_val(lo_neg, int'(lo_mag));
        chk({tag, " valid R4"}, int'(out_valid), int'(exp_valid));
        chk({tag, " hi R5"}, h, exp_h);
        chk({tag, " mid R6"}, m, exp_m);
        chk({tag, " lo R2"}, l, exp_l);
        chk({tag, " hi sign R7"}, int'(hi_neg), int'(exp_h < 0));
        chk({tag, " mid sign R7"}, int'(mid_neg), int'(exp_m < 0));
        chk({tag, " lo sign R7"}, int'(lo_neg), int'(exp_l < 0));
        chk({tag, " range R3"},
            int'(h >= -8 && h <= 7 && m >= -4 && m <= 3 && l >= -4 && l <= 3), 1);
    endtask

    task automatic apply(input logic v, input int x, input string tag);
        @(negedge clk);
        in_valid  = v;
        in_sample = 8'(x);
        @(posedge clk);
        #1;
        if (v) begin
            model(x);
            chk({tag, " sum R2"}, 16 * sm_val(hi_neg, int'(hi_mag)) +
                4 * sm_val(mid_neg, int'(mid_mag)) + sm_val(lo_neg, int'(lo_mag)), x);
        end
        check_outputs(tag, v);
    endtask

    task automatic apply_reset(input int x);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_sample = 8'(x);
        @(posedge clk);
        #1;
        e1 = 0; e2 = 0;
        exp_h = 0; exp_m = 0; exp_l = 0;
        check_outputs("reset R1", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        int dc_sum;
        seed_dummy = $urandom(32'd20240611);
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check_outputs("reset R1", 1'b0);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) apply(1'b1, 0, "zero after reset R1");

        // R3: extremes drive clamp and saturation
        for (int i = 0; i < 6; i++) apply(1'b1, 127, "max R3");
        for (int i = 0; i < 6; i++) apply(1'b1, -128, "min R3");
        for (int i = 0; i < 6; i++) apply(1'b1, (i % 2) ? 127 : -128, "alt R3");

        // R4 and R8: gaps hold codes and keep residues
        apply(1'b1, 23, "pre gap R8");
        for (int i = 0; i < 3; i++) apply(1'b0, 99, "gap R4");
        apply(1'b1, 23, "post gap R8");

        // R1: reset colliding with a sample mid-stream
        apply(1'b1, 77, "before reset");
        apply(1'b1, -51, "before reset");
        apply_reset(-99);
        for (int i = 0; i < 3; i++) apply(1'b1, 0, "zero after mid reset R1");

        // R9: DC mean of the coarse segment
        dc_sum = 0;
        for (int i = 0; i < 64; i++) begin
            apply(1'b1, 37, "dc R9");
            dc_sum += 16 * sm_val(hi_neg, int'(hi_mag));
        end
        chk("dc mean R9", int'((dc_sum - 64 * 37) <= 16 && (dc_sum - 64 * 37) >= -16), 1);

        // random stream with random gaps and extreme bias
        for (int i = 0; i < 3000; i++) begin
            int x;
            logic v;
            v = ($urandom % 5) != 0;
            case ($urandom % 6)
                0: x = 127;
                1: x = -128;
                default: x = int'($urandom % 256) - 128;
            endcase
            apply(v, x, "random R5");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule